// File: doc/BRIEF.md
# Receive-Side Sequence Checker

This block sits on the receive end of a diagnostic data path. It watches one or more incoming word streams in the data clock domain. Each stream carries either a pseudo-random sequence or an incrementing counter. The checker takes the first accepted word after it is switched on as its starting point. It then predicts every later word and compares each arrival with that prediction.

When any arrival differs from the prediction, the checker raises a sticky error flag. It keeps a "nothing seen yet" flag set until the first word arrives, and it counts the words it has accepted. Software controls each stream and reads its result through a small register window in the management clock domain. Each stream has its own window: the window for stream n starts at word address n * 2^REG_AW.

The stream is treated as a monitor tap. A word is accepted on every data-clock cycle in which its valid bit is high. Only the low 32 bits of each data word take part in the comparison.

Top module: `stream_seq_checker`

## Requirements
- R1: Word offset 0 of a stream window is the control register, reset to 0. Bit 0 turns checking on and bit 1 picks the pattern (0 = pseudo-random, 1 = counter). Its value reads back one management cycle after the read strobe.
- R2: While checking is off, the status word reads 2 (bit 1 set, bit 0 clear) and the count at offset 2 reads 0, even if words keep arriving.
- R3: With checking on and no word accepted yet, the status word at offset 1 reads 2 and the count reads 0.
- R4: The first accepted word after checking is turned on seeds the predictor and clears status bit 1. A clean stream then leaves status at 0.
- R5: In counter mode each word must equal the previous expected word plus 1, modulo 2^32, including across the wrap from all-ones to zero.
- R6: In pseudo-random mode each word must equal the previous expected word x shifted left by one, with bit 0 filled by x[31]^x[21]^x[1]^x[0].
- R7: A word that differs from its prediction sets status bit 0. The bit stays set while later words match, and the predictor keeps advancing from its own prediction.
- R8: The count at offset 2 rises by one for every accepted word while checking is on, and holds in cycles without a valid word.
- R9: Turning checking off and on again clears the error bit and the count, and sets status bit 1 again.
- R10: Data bits above bit 31 have no effect on the comparison.
- R11: Stream windows are independent; register offsets 3 and above read 0.
- R12: A control write takes effect in the data domain within 10 management cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mm_clk | input | 1 | Management clock |
| mm_rst | input | 1 | Synchronous active-high reset, management domain |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Word address: stream index above REG_AW offset bits |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid one cycle after reg_rd |
| dp_clk | input | 1 | Data clock |
| dp_rst | input | 1 | Synchronous active-high reset, data domain |
| in_valid | input | NUM_STREAMS | Per-stream word valid |
| in_data | input | NUM_STREAMS*DATA_W | Per-stream data words, stream 0 in the low bits |

## Verification
The bench builds the block with two streams, a 40-bit data field and 2-bit register offsets. This exercises window decoding across a stream boundary, shows the two lanes staying independent, and lets random upper data bits prove that only the low word is compared. A 32-bit count and two-stage synchronizers keep the gray-coded count crossing at its real width. The data clock is deliberately unrelated to the management clock, so the settle time from a control write is covered as well.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;
  localparam int WORD_W = 32;

  typedef enum logic {PAT_PRBS = 1'b0, PAT_COUNT = 1'b1} pat_e;

  localparam logic [1:0] OFS_CTRL = 2'd0;
  localparam logic [1:0] OFS_STAT = 2'd1;
  localparam logic [1:0] OFS_CNT  = 2'd2;

  function automatic logic [WORD_W-1:0] seq_next(input pat_e p, input logic [WORD_W-1:0] x);
    if (p == PAT_COUNT) return x + 1'b1;
    return {x[WORD_W-2:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction
endpackage

// File: rtl/seqchk_sync.sv
module seqchk_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/seqchk_lane.sv
module seqchk_lane
  import seqchk_pkg::*;
#(
  parameter int DATA_W = 40,
  parameter int CNT_W = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              dp_clk,
  input  logic              dp_rst,
  input  logic [1:0]        ctrl_async,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              err_q,
  output logic              nores_q,
  output logic [CNT_W-1:0]  cnt_gray_q
);
  logic [1:0]        ctrl_s;
  logic              en_s;
  pat_e              pat_s;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] pred;
  logic [CNT_W-1:0]  cnt;

  seqchk_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b00)) u_ctrl_sync (
    .clk(dp_clk), .rst(dp_rst), .d(ctrl_async), .q(ctrl_s)
  );

  assign en_s  = ctrl_s[0];
  assign pat_s = pat_e'(ctrl_s[1]);
  assign word  = in_data[WORD_W-1:0];

  if (DATA_W > WORD_W) begin : g_hi
    logic unused_hi;
    assign unused_hi = ^in_data[DATA_W-1:WORD_W];
  end

  always_ff @(posedge dp_clk) begin
    if (dp_rst || !en_s) begin
      nores_q <= 1'b1;
      err_q   <= 1'b0;
      pred    <= '0;
      cnt     <= '0;
    end else if (in_valid) begin
      if (cnt != '1) cnt <= cnt + 1'b1;
      if (nores_q) begin
        nores_q <= 1'b0;
        pred    <= seq_next(pat_s, word);
      end else begin
        if (word != pred) err_q <= 1'b1;
        pred <= seq_next(pat_s, pred);
      end
    end
  end

  always_ff @(posedge dp_clk) begin
    if (dp_rst) cnt_gray_q <= '0;
    else        cnt_gray_q <= cnt ^ (cnt >> 1);
  end

  AST_OFF_CLEARS: assert property (@(posedge dp_clk) disable iff (dp_rst)
    !en_s |=> (cnt == '0 && !err_q && nores_q)); // R9
  AST_ERR_STICKY: assert property (@(posedge dp_clk) disable iff (dp_rst)
    (en_s && err_q) |=> err_q); // R7
  AST_CNT_HOLD: assert property (@(posedge dp_clk) disable iff (dp_rst)
    (en_s && !in_valid) |=> $stable(cnt)); // R8
  AST_CNT_STEP: assert property (@(posedge dp_clk) disable iff (dp_rst)
    (en_s && in_valid && cnt != '1) |=> cnt == $past(cnt) + 1'b1); // R8
  AST_NORES_EMPTY: assert property (@(posedge dp_clk) disable iff (dp_rst)
    nores_q |-> cnt == '0); // R3
  AST_SEED_CLEARS: assert property (@(posedge dp_clk) disable iff (dp_rst)
    (en_s && nores_q && in_valid) |=> !nores_q); // R4
endmodule

// File: rtl/stream_seq_checker.sv
module stream_seq_checker
  import seqchk_pkg::*;
#(
  parameter int NUM_STREAMS = 2,
  parameter int DATA_W = 40,
  parameter int CNT_W = 32,
  parameter int REG_AW = 2,
  parameter int SYNC_STAGES = 2,
  parameter int SEL_W = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  parameter int ADDR_W = REG_AW + SEL_W
) (
  input  logic                          mm_clk,
  input  logic                          mm_rst,
  input  logic                          reg_wr,
  input  logic                          reg_rd,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [31:0]                   reg_wdata,
  output logic [31:0]                   reg_rdata,
  input  logic                          dp_clk,
  input  logic                          dp_rst,
  input  logic [NUM_STREAMS-1:0]        in_valid,
  input  logic [NUM_STREAMS*DATA_W-1:0] in_data
);
  logic [NUM_STREAMS-1:0][1:0] ctrl_q;
  logic                        stat_err   [NUM_STREAMS];
  logic                        stat_nores [NUM_STREAMS];
  logic [CNT_W-1:0]            cnt_mm     [NUM_STREAMS];
  logic [SEL_W-1:0]            sel_idx;
  logic [REG_AW-1:0]           reg_off;
  logic                        sel_ok;
  logic                        unused_wdata;

  assign sel_idx      = reg_addr[ADDR_W-1:REG_AW];
  assign reg_off      = reg_addr[REG_AW-1:0];
  assign sel_ok       = 32'(sel_idx) < NUM_STREAMS;
  assign unused_wdata = ^reg_wdata[31:2];

  always_ff @(posedge mm_clk) begin
    if (mm_rst) ctrl_q <= '0;
    else if (reg_wr && sel_ok && reg_off == REG_AW'(OFS_CTRL))
      ctrl_q[sel_idx] <= reg_wdata[1:0];
  end

  for (genvar s = 0; s < NUM_STREAMS; s++) begin : g_lane
    logic             err_d, nores_d, err_m, nores_m;
    logic [CNT_W-1:0] gray_d, gray_m;

    seqchk_lane #(.DATA_W(DATA_W), .CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_lane (
      .dp_clk(dp_clk), .dp_rst(dp_rst), .ctrl_async(ctrl_q[s]),
      .in_valid(in_valid[s]), .in_data(in_data[s*DATA_W +: DATA_W]),
      .err_q(err_d), .nores_q(nores_d), .cnt_gray_q(gray_d)
    );

    seqchk_sync #(.W(CNT_W + 2), .STAGES(SYNC_STAGES),
                  .RST_VAL({1'b1, 1'b0, {CNT_W{1'b0}}})) u_stat_sync (
      .clk(mm_clk), .rst(mm_rst), .d({nores_d, err_d, gray_d}),
      .q({nores_m, err_m, gray_m})
    );

    always_comb begin
      logic [CNT_W-1:0] b;
      b[CNT_W-1] = gray_m[CNT_W-1];
      for (int i = CNT_W - 2; i >= 0; i--) b[i] = b[i+1] ^ gray_m[i];
      cnt_mm[s] = b;
    end

    assign stat_err[s]   = err_m;
    assign stat_nores[s] = nores_m;
  end

  always_ff @(posedge mm_clk) begin
    if (mm_rst) reg_rdata <= '0;
    else if (reg_rd) begin
      reg_rdata <= '0;
      if (sel_ok) begin
        case (reg_off)
          REG_AW'(OFS_CTRL): reg_rdata <= {30'd0, ctrl_q[sel_idx]};
          REG_AW'(OFS_STAT): reg_rdata <= {30'd0, stat_nores[sel_idx], stat_err[sel_idx]};
          REG_AW'(OFS_CNT):  reg_rdata <= 32'(cnt_mm[sel_idx]);
          default:           reg_rdata <= '0;
        endcase
      end
    end
  end

  AST_CTRL_HOLD: assert property (@(posedge mm_clk) disable iff (mm_rst)
    !reg_wr |=> $stable(ctrl_q)); // R1
endmodule

// File: tb/stream_seq_checker_test.sv
module stream_seq_checker_test;
  localparam int NS = 2;
  localparam int DW = 40;

  logic mm_clk = 1'b0, dp_clk = 1'b0;
  logic mm_rst = 1'b1, dp_rst = 1'b1;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NS-1:0] in_valid = '0;
  logic [NS*DW-1:0] in_data = '0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #2.5 mm_clk = ~mm_clk;
  always #3 dp_clk = ~dp_clk;

  stream_seq_checker #(.NUM_STREAMS(NS), .DATA_W(DW), .CNT_W(32), .REG_AW(2)) uut (
    .mm_clk(mm_clk), .mm_rst(mm_rst), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dp_clk(dp_clk), .dp_rst(dp_rst), .in_valid(in_valid), .in_data(in_data)
  );

  function automatic logic [31:0] nxt(input bit pat, input logic [31:0] x);
    if (pat) return x + 32'd1;
    return {x[30:0], x[31] ^ x[21] ^ x[1] ^ x[0]};
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic mm_write(input int a, input logic [31:0] d);
    @(negedge mm_clk);
    reg_addr = 3'(a); reg_wdata = d; reg_wr = 1'b1;
    @(negedge mm_clk);
    reg_wr = 1'b0;
  endtask

  task automatic mm_read(input int a, output logic [31:0] d);
    @(negedge mm_clk);
    reg_addr = 3'(a); reg_rd = 1'b1;
    @(negedge mm_clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic settle();
    repeat (14) @(negedge mm_clk);
  endtask

  task automatic expect_reg(input string req, input int a, input logic [31:0] exp);
    logic [31:0] d;
    mm_read(a, d);
    check(req, d, exp);
  endtask

  // bad_idx < 0 means no corrupted word
  task automatic send_words(input int s, input bit pat, inout logic [31:0] e,
                            input int n, input int bad_idx);
    for (int i = 0; i < n; i++) begin
      logic [31:0] w;
      @(negedge dp_clk);
      if ($urandom_range(0, 3) == 0) begin
        in_valid[s] = 1'b0;
        in_data[s*DW +: DW] = {8'($urandom()), $urandom()};
        @(negedge dp_clk);
      end
      w = (i == bad_idx) ? (e ^ 32'h0000_0010) : e;
      in_data[s*DW +: DW] = {8'($urandom()), w};
      in_valid[s] = 1'b1;
      e = nxt(pat, e);
    end
    @(negedge dp_clk);
    in_valid[s] = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge mm_clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] e0, e1;
    void'($urandom(32'h5EED_0042));
    repeat (10) @(negedge mm_clk);
    mm_rst = 1'b0; dp_rst = 1'b0;
    settle();

    // reset state
    expect_reg("R1 ctrl reset", 0, 32'd0);
    expect_reg("R2 stat when off", 1, 32'd2);
    expect_reg("R2 cnt when off", 2, 32'd0);
    expect_reg("R2 stream1 stat when off", 5, 32'd2);

    // enable counter mode on stream 0
    mm_write(0, 32'd3);
    expect_reg("R1 ctrl readback", 0, 32'd3);
    settle();
    expect_reg("R3 stat armed no data", 1, 32'd2);
    expect_reg("R3 cnt armed no data", 2, 32'd0);

    e0 = $urandom();
    send_words(0, 1'b1, e0, 20, -1);
    settle();
    expect_reg("R4 R5 stat clean counter", 1, 32'd0);
    expect_reg("R8 cnt after 20", 2, 32'd20);

    send_words(0, 1'b1, e0, 12, -1);
    settle();
    expect_reg("R10 stat with random upper bits", 1, 32'd0);
    expect_reg("R8 cnt after 32", 2, 32'd32);

    send_words(0, 1'b1, e0, 6, 2);
    settle();
    expect_reg("R7 stat after mismatch", 1, 32'd1);
    send_words(0, 1'b1, e0, 6, -1);
    settle();
    expect_reg("R7 stat sticky", 1, 32'd1);
    expect_reg("R8 cnt after 44", 2, 32'd44);

    // disable: words ignored
    mm_write(0, 32'd2);
    settle();
    expect_reg("R9 stat after off", 1, 32'd2);
    expect_reg("R2 cnt after off", 2, 32'd0);
    send_words(0, 1'b1, e0, 5, -1);
    settle();
    expect_reg("R2 cnt stays 0 when off", 2, 32'd0);
    expect_reg("R1 ctrl readback off", 0, 32'd2);

    // re-enable, only 10 mm cycles before data, wrap case
    mm_write(0, 32'd3);
    repeat (10) @(negedge mm_clk);
    e0 = 32'hFFFF_FFFE;
    send_words(0, 1'b1, e0, 4, -1);
    settle();
    expect_reg("R5 R9 stat across wrap", 1, 32'd0);
    expect_reg("R12 cnt after quick enable", 2, 32'd4);

    // stream 1, pseudo-random
    mm_write(4, 32'd1);
    settle();
    e1 = $urandom() | 32'd1;
    send_words(1, 1'b0, e1, 25, -1);
    settle();
    expect_reg("R6 stream1 stat clean prbs", 5, 32'd0);
    expect_reg("R6 stream1 cnt", 6, 32'd25);
    expect_reg("R11 stream0 cnt untouched", 2, 32'd4);
    send_words(1, 1'b0, e1, 8, 5);
    settle();
    expect_reg("R6 R7 stream1 prbs mismatch", 5, 32'd1);
    expect_reg("R11 stream0 stat untouched", 1, 32'd0);
    expect_reg("R11 offset 3 reads 0", 3, 32'd0);
    expect_reg("R11 stream1 offset 3 reads 0", 7, 32'd0);
    expect_reg("R11 stream1 ctrl", 4, 32'd1);

    // constrained random rounds
    for (int r = 0; r < 8; r++) begin
      int s, n, bad;
      bit pat;
      logic [31:0] e;
      s = $urandom_range(0, 1);
      pat = 1'($urandom_range(0, 1));
      n = $urandom_range(0, 30);
      bad = (n >= 2 && $urandom_range(0, 1) == 1) ? $urandom_range(1, n - 1) : -1;
      mm_write(s * 4, {30'd0, pat, 1'b0});
      settle();
      mm_write(s * 4, {30'd0, pat, 1'b1});
      settle();
      e = $urandom();
      send_words(s, pat, e, n, bad);
      settle();
      expect_reg("R9 R7 random stat", s * 4 + 1,
                 (bad >= 0) ? 32'd1 : ((n == 0) ? 32'd2 : 32'd0));
      expect_reg("R8 random cnt", s * 4 + 2, 32'(n));
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule